// File: doc/BRIEF.md
# Montgomery Ladder Step Controller

This block drives constant-time scalar multiplication over a group whose points are each made of four field elements. On a start pulse it captures a secret scalar, a base point and a fixed starting point, then walks the scalar from its top bit to its bottom bit. Each bit costs one ladder round: a conditional exchange of the two working points, one call to an external combined doubling and differential-addition unit, and a second conditional exchange under the same bit.

The external unit is reached through a one-cycle request strobe with operands and a completion strobe with results. The controller does no field arithmetic. When the bottom bit's round finishes, it raises a one-cycle completion pulse. At that point the first working point holds the scalar multiple of the base point and the second holds the next multiple. The length of a run depends only on the scalar width and on the latency of the external unit. The key bits never change it.

Top module: `ladder_seq`

## Requirements
- R1: While reset is held and after it is released, `done` and `op_start` are 0.
- R2: On a `start` pulse in idle, working point A is loaded from `init_pt` and working point B from `base_pt`. The scalar and the base point are latched.
- R3: Scalar bits are consumed from bit NBITS-1 down to bit 0, one external call per bit, so one run issues exactly NBITS one-cycle `op_start` pulses.
- R4: In each round, if the current bit is 1, the two working points are exchanged both before and after the call. If the bit is 0, they stay in place. Each exchange takes one cycle in both cases.
- R5: During a call, `op_a` carries working point A, `op_b` carries working point B, and `op_diff` carries the latched base point.
- R6: In the cycle `op_done` is 1, A takes `op_dbl` and B takes `op_sum`. While waiting, both points hold.
- R7: With an external unit of fixed latency L cycles, `done` is seen NBITS*(3+L) cycles after the clock edge that samples `start`, whatever the key bits.
- R8: `start` has no effect while a run is in progress. The latched scalar and base point keep driving the run, and only one `done` pulse is produced.
- R9: `done` is a one-cycle pulse. After it, `pt_a` = [k]P and `pt_b` = [k+1]P, where the ladder starts from `init_pt`. Both values hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scalar multiplication |
| scalar | input | NBITS | Secret scalar k |
| base_pt | input | 4*ELEM_W | Base point P, four packed elements |
| init_pt | input | 4*ELEM_W | Fixed starting point for A |
| done | output | 1 | One-cycle completion pulse |
| pt_a | output | 4*ELEM_W | Working point A, [k]P at completion |
| pt_b | output | 4*ELEM_W | Working point B, [k+1]P at completion |
| op_start | output | 1 | Request strobe to the double-add unit |
| op_a | output | 4*ELEM_W | First operand (to be doubled) |
| op_b | output | 4*ELEM_W | Second operand |
| op_diff | output | 4*ELEM_W | Difference operand (base point) |
| op_done | input | 1 | Completion strobe from the double-add unit |
| op_dbl | input | 4*ELEM_W | Doubled first operand |
| op_sum | input | 4*ELEM_W | Differential sum of the operands |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a run together with a different scalar and base point. The bench raises `start` between calls, changes both inputs, and then holds them at the new values. The result and the run length must still match the original inputs, and only one completion pulse may appear. The bench stands in for the external unit with element-wise doubling and addition at a fixed latency. Under that model the ladder gives plain integer multiples, so scalars of all zeros, all ones and mixed bits each give a distinct result that a reference loop computes independently.

// File: rtl/ladder_seq.sv
module ladder_seq #(
  parameter int ELEM_W = 16,
  parameter int NBITS  = 8,
  localparam int PT_W  = 4 * ELEM_W,
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBITS-1:0] scalar,
  input  logic [PT_W-1:0] base_pt,
  input  logic [PT_W-1:0] init_pt,
  output logic            done,
  output logic [PT_W-1:0] pt_a,
  output logic [PT_W-1:0] pt_b,
  output logic            op_start,
  output logic [PT_W-1:0] op_a,
  output logic [PT_W-1:0] op_b,
  output logic [PT_W-1:0] op_diff,
  input  logic            op_done,
  input  logic [PT_W-1:0] op_dbl,
  input  logic [PT_W-1:0] op_sum
);

  typedef enum logic [2:0] {S_IDLE, S_SW1, S_CALL, S_WAIT, S_SW2, S_FIN} st_t;

  st_t              st_q;
  logic [IDX_W-1:0] idx_q;
  logic [NBITS-1:0] key_q;
  logic [PT_W-1:0]  a_q, b_q, pb_q;

  logic             kbit;
  logic [PT_W-1:0]  xdiff;

  assign kbit  = key_q[idx_q];
  assign xdiff = {PT_W{kbit}} & (a_q ^ b_q);

  assign done     = (st_q == S_FIN);
  assign op_start = (st_q == S_CALL);
  assign op_a     = a_q;
  assign op_b     = b_q;
  assign op_diff  = pb_q;
  assign pt_a     = a_q;
  assign pt_b     = b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      key_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      pb_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          a_q   <= init_pt;
          b_q   <= base_pt;
          pb_q  <= base_pt;
          key_q <= scalar;
          idx_q <= IDX_W'(NBITS - 1);
          st_q  <= S_SW1;
        end
        S_SW1: begin
          a_q  <= a_q ^ xdiff;
          b_q  <= b_q ^ xdiff;
          st_q <= S_CALL;
        end
        S_CALL: st_q <= S_WAIT;
        S_WAIT: if (op_done) begin
          a_q  <= op_dbl;
          b_q  <= op_sum;
          st_q <= S_SW2;
        end
        S_SW2: begin
          a_q <= a_q ^ xdiff;
          b_q <= b_q ^ xdiff;
          if (idx_q == '0) st_q <= S_FIN;
          else begin
            idx_q <= idx_q - 1'b1;
            st_q  <= S_SW1;
          end
        end
        S_FIN: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !done && !op_start);

  p_call_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  p_swap_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SW1 || st_q == S_SW2) |=>
      ((a_q == $past(b_q) && b_q == $past(a_q)) ||
       (a_q == $past(a_q) && b_q == $past(b_q))));

  p_swap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_SW1 || st_q == S_SW2) && !kbit) |=> $stable(a_q) && $stable(b_q));

  p_diff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |=> $stable(op_diff));

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && !op_done) |=> $stable(pt_a) && $stable(pt_b));

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE && start) |=> $stable(key_q) && $stable(pb_q));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && $stable(pt_a) && $stable(pt_b));

endmodule

// File: tb/ladder_seq_test.sv
module ladder_seq_test;
  localparam int EW  = 16;
  localparam int NB  = 8;
  localparam int PW  = 4 * EW;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NB-1:0] scalar = '0;
  logic [PW-1:0] base_pt = '0, init_pt = '0;
  logic done, op_start, op_done;
  logic [PW-1:0] pt_a, pt_b, op_a, op_b, op_diff, op_dbl, op_sum;

  int total = 0, bad = 0, calls = 0, diff_bad = 0, cnt = 0;
  logic [PW-1:0] cap_a, cap_b, want_diff;
  bit finished = 0;

  always #10 clk = ~clk;

  ladder_seq #(.ELEM_W(EW), .NBITS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .scalar(scalar),
    .base_pt(base_pt), .init_pt(init_pt), .done(done), .pt_a(pt_a), .pt_b(pt_b),
    .op_start(op_start), .op_a(op_a), .op_b(op_b), .op_diff(op_diff),
    .op_done(op_done), .op_dbl(op_dbl), .op_sum(op_sum));

  function automatic logic [PW-1:0] pdbl(input logic [PW-1:0] p);
    logic [PW-1:0] r;
    for (int e = 0; e < 4; e++) r[e*EW +: EW] = p[e*EW +: EW] << 1;
    return r;
  endfunction

  function automatic logic [PW-1:0] padd(input logic [PW-1:0] p, input logic [PW-1:0] q);
    logic [PW-1:0] r;
    for (int e = 0; e < 4; e++) r[e*EW +: EW] = p[e*EW +: EW] + q[e*EW +: EW];
    return r;
  endfunction

  // stand-in double-add unit, fixed latency
  assign op_done = (cnt == 1);
  assign op_dbl  = pdbl(cap_a);
  assign op_sum  = padd(cap_a, cap_b);

  always @(posedge clk) begin
    if (op_start) begin
      cap_a <= op_a;
      cap_b <= op_b;
      cnt   <= LAT;
      calls <= calls + 1;
      if (op_diff !== want_diff) diff_bad <= diff_bad + 1;
    end else if (cnt > 0) cnt <= cnt - 1;
  end

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic ref_ladder(input logic [NB-1:0] k, input logic [PW-1:0] c, input logic [PW-1:0] p,
                            output logic [PW-1:0] ra, output logic [PW-1:0] rb);
    logic [PW-1:0] x, y, t;
    x = c; y = p;
    for (int i = NB - 1; i >= 0; i--) begin
      if (k[i]) begin t = x; x = y; y = t; end
      t = pdbl(x); y = padd(x, y); x = t;
      if (k[i]) begin t = x; x = y; y = t; end
    end
    ra = x; rb = y;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 0 && op_start == 0, "R1 in reset", {62'b0, done, op_start}, '0);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0 && op_start == 0, "R1 after reset", {62'b0, done, op_start}, '0);
  endtask

  // drives one run; optionally disturbs start mid-run
  task automatic t_run(input logic [NB-1:0] k, input logic [PW-1:0] c, input logic [PW-1:0] p,
                       input bit disturb, input string tag);
    logic [PW-1:0] ea, eb, ha, hb;
    int cyc, dones;
    ref_ladder(k, c, p, ea, eb);
    @(negedge clk);
    scalar = k; init_pt = c; base_pt = p; want_diff = p; start = 1;
    calls = 0; diff_bad = 0; dones = 0;
    @(posedge clk);
    cyc = 1;
    @(negedge clk);
    start = 0;
    chk(pt_a === c && pt_b === p, {"R2 load ", tag}, pt_a, c);
    while (cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (disturb && cyc == 10) begin
        start = 1; scalar = ~k; base_pt = ~p; init_pt = ~c;
      end
      if (disturb && cyc == 11) start = 0;
      if (done) break;
    end
    dones++;
    chk(cyc == 1 + NB * (3 + LAT), {"R7 cycles ", tag}, PW'(cyc), PW'(1 + NB * (3 + LAT)));
    chk(calls == NB, {"R3 calls ", tag}, PW'(calls), PW'(NB));
    chk(diff_bad == 0, {"R5 diff operand ", tag}, PW'(diff_bad), '0);
    chk(pt_a === ea, {"R4 R6 R9 pt_a ", tag}, pt_a, ea);
    chk(pt_b === eb, {"R4 R6 R9 pt_b ", tag}, pt_b, eb);
    ha = pt_a; hb = pt_b;
    for (int j = 0; j < 6; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) dones++;
    end
    chk(dones == 1, {"R9 R8 single done ", tag}, PW'(dones), PW'(1));
    chk(pt_a === ha && pt_b === hb, {"R9 hold ", tag}, pt_a, ha);
    if (disturb) begin
      chk(calls == NB, "R8 no restart", PW'(calls), PW'(NB));
      base_pt = p; scalar = k; init_pt = c;
    end
  endtask

  initial begin
    t_reset();
    t_run(8'h00, '0, 64'h0001_0002_0003_0004, 0, "k=00");
    t_run(8'hFF, '0, 64'h0001_0002_0003_0004, 0, "k=FF");
    t_run(8'hA5, '0, 64'h0003_0005_0007_0009, 0, "k=A5");
    t_run(8'h80, '0, 64'h1111_2222_3333_4444, 0, "k=80");
    t_run(8'h01, 64'h0009_0008_0007_0006, 64'h0101_0202_0303_0404, 0, "k=01 nonzero init");
    t_run(8'h5C, 64'h0002_0000_0001_0003, 64'hF00D_0BAD_1234_0042, 0, "k=5C nonzero init");
    t_run(8'h3B, '0, 64'h0010_0020_0030_0040, 1, "k=3B start while busy");
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule